// File: doc/BRIEF.md
# Multi-Step Converter Fine/Coarse Merge with Redundant Correction

This block produces the final code of a multi-step flash analog-to-digital converter. The earlier conversion steps deliver a 10-bit coarse code that places the held input between two adjacent ladder taps. The last flash step delivers a 16-bit thermometer word. Four of its levels split the tap interval into quarter steps. Six extra levels lie below the low tap and six lie above the high tap.

The block counts the ones in the thermometer word and subtracts six. This gives a signed fine offset from -6 to +10, measured in quarter steps of the coarse code. It adds that offset to the coarse code times four. An error of a few quarter steps in an earlier coarse decision is therefore repaired, not carried into the result. The sum is held to the range 0..4095, registered on an input strobe, and flagged by a one-cycle valid pulse.

Top module: `mstep_corrector`

## Requirements
- R1: A synchronous active-high `rst` clears `result` to 0 and `result_valid` to 0 at the next rising clock edge.
- R2: The fine count is the number of ones in `fine_therm`, from 0 to 16. The signed fine offset is that count minus 6. Bit 0 of `fine_therm` is the lowest fine level.
- R3: When `in_valid` is high at a rising edge, and no clamp applies, `result` becomes `coarse_code*4 + count - 6` at that same edge.
- R4: If `coarse_code*4 + count - 6` is below 0, `result` becomes 0. Example: coarse 0 with a count of 0 to 5.
- R5: If `coarse_code*4 + count - 6` is above 4095, `result` becomes 4095. Example: coarse 1023 with a count of 10 to 16.
- R6: `result_valid` is high for exactly the one cycle that follows each rising edge at which `in_valid` was high. It is low after any edge at which `in_valid` was low.
- R7: At an edge where `in_valid` is low, `result` keeps its value, whatever `coarse_code` and `fine_therm` carry.
- R8: A word that is not a clean thermometer is decoded by its number of ones alone. A single bubble therefore moves the result by at most one code compared with the intended thermometer word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: capture this cycle's inputs |
| coarse_code | input | 10 | Coarse code from the earlier steps |
| fine_therm | input | 16 | Thermometer word from the final flash, bit 0 lowest |
| result | output | 12 | Corrected, clamped code |
| result_valid | output | 1 | One-cycle pulse marking a new result |

## Verification
The bench drives the extremes of the coarse range with full and empty thermometer words, because these are where both clamps act.

- A merge that wraps in 12 bits, instead of clamping, returns 4090 near zero or small codes near full scale.
- Words at count 6 and count 5 probe the zero point of the offset. A missing or wrong bias of six shifts every result.
- Bubbled, scrambled and alternating words catch a decoder that searches for a transition instead of counting ones. Such a decoder gives large jumps on these words.
- Strobe-free cycles with changing inputs catch a register that loads without the strobe, or a valid flag that stretches past one cycle.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;

    parameter int COARSE_W   = 10;
    parameter int SUB_BITS   = 2;
    parameter int FINE_LVLS  = 16;
    parameter int FINE_BELOW = 6;

    localparam int OUT_W   = COARSE_W + SUB_BITS;
    localparam int SUM_W   = OUT_W + 2;
    localparam int CNT_W   = $clog2(FINE_LVLS + 1);
    localparam int OUT_MAX = (1 << OUT_W) - 1;

    typedef logic [CNT_W-1:0]        fine_cnt_t;
    typedef logic signed [SUM_W-1:0] wide_sum_t;

    typedef struct packed {
        logic             valid;
        logic [OUT_W-1:0] code;
    } merged_t;

    // Signed quarter-step offset derived from the fine count.
    function automatic wide_sum_t fine_offset(input fine_cnt_t cnt);
        return wide_sum_t'({{(SUM_W-CNT_W){1'b0}}, cnt}) - wide_sum_t'(FINE_BELOW);
    endfunction

    // Coarse code placed on the fine grid.
    function automatic wide_sum_t coarse_scaled(input logic [COARSE_W-1:0] c);
        return wide_sum_t'({{(SUM_W-OUT_W){1'b0}}, c, {SUB_BITS{1'b0}}});
    endfunction

endpackage

// File: rtl/therm_counter.sv
module therm_counter
    import adc_corr_pkg::*;
(
    input  logic [FINE_LVLS-1:0] therm,
    output fine_cnt_t            count
);
    fine_cnt_t bit_ext [FINE_LVLS];

    genvar g;
    generate
        for (g = 0; g < FINE_LVLS; g++) begin : g_ext
            assign bit_ext[g] = fine_cnt_t'(therm[g]);
        end
    endgenerate

    always_comb begin
        count = '0;
        for (int i = 0; i < FINE_LVLS; i++) begin
            count = count + bit_ext[i];
        end
    end
endmodule

// File: rtl/offset_merge.sv
module offset_merge
    import adc_corr_pkg::*;
(
    input  logic [COARSE_W-1:0] coarse,
    input  fine_cnt_t           count,
    output logic [OUT_W-1:0]    code
);
    wide_sum_t sum;

    always_comb begin
        sum = coarse_scaled(coarse) + fine_offset(count);
        if (sum < 0) begin
            code = '0;
        end else if (sum > wide_sum_t'(OUT_MAX)) begin
            code = OUT_W'(OUT_MAX);
        end else begin
            code = sum[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/result_stage.sv
module result_stage
    import adc_corr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [OUT_W-1:0] next_code,
    output merged_t          q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.valid <= load;
            if (load) begin
                q.code <= next_code;
            end
        end
    end
endmodule

// File: rtl/mstep_corrector.sv
module mstep_corrector
    import adc_corr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [COARSE_W-1:0]  coarse_code,
    input  logic [FINE_LVLS-1:0] fine_therm,
    output logic [OUT_W-1:0]     result,
    output logic                 result_valid
);
    fine_cnt_t        fine_count;
    logic [OUT_W-1:0] merged_code;
    merged_t          out_q;

    therm_counter u_count (
        .therm (fine_therm),
        .count (fine_count)
    );

    offset_merge u_merge (
        .coarse (coarse_code),
        .count  (fine_count),
        .code   (merged_code)
    );

    result_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .load      (in_valid),
        .next_code (merged_code),
        .q         (out_q)
    );

    assign result       = out_q.code;
    assign result_valid = out_q.valid;
endmodule

// File: rtl/mstep_corrector_chk.sv
module mstep_corrector_chk
    import adc_corr_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [COARSE_W-1:0]  coarse_code,
    input logic [FINE_LVLS-1:0] fine_therm,
    input logic [OUT_W-1:0]     result,
    input logic                 result_valid
);
    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> result_valid);

    // R6
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !result_valid);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    // R4
    floor_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && coarse_code == '0 && fine_therm == '0) |=> result == '0);

    // R5
    ceil_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && coarse_code == '1 && fine_therm == '1) |=> result == '1);
endmodule

bind mstep_corrector mstep_corrector_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .coarse_code  (coarse_code),
    .fine_therm   (fine_therm),
    .result       (result),
    .result_valid (result_valid)
);

// File: tb/mstep_corrector_tb.sv
module mstep_corrector_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [9:0]  coarse_code;
    logic [15:0] fine_therm;
    logic [11:0] result;
    logic        result_valid;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    mstep_corrector u_dut (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .coarse_code  (coarse_code),
        .fine_therm   (fine_therm),
        .result       (result),
        .result_valid (result_valid)
    );

    function automatic int ones(input logic [15:0] w);
        int n = 0;
        for (int i = 0; i < 16; i++) n += int'(w[i]);
        return n;
    endfunction

    function automatic int expect_code(input logic [9:0] c, input logic [15:0] w);
        int s = int'(c) * 4 + ones(w) - 6;
        if (s < 0) s = 0;
        if (s > 4095) s = 4095;
        return s;
    endfunction

    function automatic logic [15:0] therm_of(input int n);
        logic [15:0] w = '0;
        for (int i = 0; i < 16; i++) w[i] = (i < n);
        return w;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One strobed sample: drive at negedge, sample 1 ns after the capture edge.
    task automatic strobe(input string req, input logic [9:0] c, input logic [15:0] w);
        @(negedge clk);
        in_valid    = 1'b1;
        coarse_code = c;
        fine_therm  = w;
        @(posedge clk);
        #1;
        check(req, int'(result), expect_code(c, w));
        check("R6 valid after strobe", int'(result_valid), 1);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        int held;
        logic [9:0]  rc;
        logic [15:0] rw;
        seed = $urandom(32'h5EED_0C0D);
        rst = 1'b1; in_valid = 1'b0; coarse_code = '0; fine_therm = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset result", int'(result), 0);
        check("R1 reset valid", int'(result_valid), 0);
        @(negedge clk);
        rst = 1'b0;

        // R2/R3: offset zero point and span
        strobe("R2 count 6 zero offset", 10'd100, therm_of(6));
        strobe("R2 count 5 minus one",   10'd100, therm_of(5));
        strobe("R3 count 16 plus ten",   10'd100, therm_of(16));
        strobe("R3 count 0 minus six",   10'd100, therm_of(0));
        // R4 floor clamp
        strobe("R4 floor coarse0 count0", 10'd0, therm_of(0));
        strobe("R4 floor coarse0 count5", 10'd0, therm_of(5));
        strobe("R4 edge coarse1 count2",  10'd1, therm_of(2));
        // R5 ceiling clamp
        strobe("R5 ceil coarse1023 full", 10'd1023, therm_of(16));
        strobe("R5 ceil coarse1023 cnt10", 10'd1023, therm_of(10));
        strobe("R5 edge coarse1023 cnt9", 10'd1023, therm_of(9));
        // R8 bubbles and scrambled words
        strobe("R8 single bubble", 10'd512, 16'b0000_0000_0111_1011);
        strobe("R8 alternating",   10'd300, 16'hAAAA);
        strobe("R8 top bits only", 10'd300, 16'hF000);

        // R6/R7: idle cycles with changing inputs
        held = int'(result);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            coarse_code = 10'($urandom);
            fine_therm  = 16'($urandom);
            @(posedge clk);
            #1;
            check("R7 result held", int'(result), held);
            check("R6 no valid without strobe", int'(result_valid), 0);
        end

        // R6: back-to-back strobes keep valid high each cycle
        @(negedge clk);
        in_valid = 1'b1; coarse_code = 10'd40; fine_therm = therm_of(7);
        @(posedge clk); #1;
        check("R3 back-to-back first", int'(result), 40*4+1);
        @(negedge clk);
        coarse_code = 10'd41; fine_therm = therm_of(3);
        @(posedge clk); #1;
        check("R3 back-to-back second", int'(result), 41*4-3);
        check("R6 valid second strobe", int'(result_valid), 1);
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk); #1;
        check("R6 valid one cycle", int'(result_valid), 0);

        // Random mix: thermometer words with and without bubbles
        for (int k = 0; k < 300; k++) begin
            rc = 10'($urandom);
            rw = therm_of(int'($urandom_range(16, 0)));
            if ($urandom_range(3, 0) == 0) rw[$urandom_range(15, 0)] ^= 1'b1;
            strobe("R3 random", rc, rw);
        end

        // R1: reset mid-run clears state
        @(negedge clk);
        in_valid = 1'b1; coarse_code = 10'd700; fine_therm = therm_of(8);
        rst = 1'b1;
        @(posedge clk); #1;
        check("R1 reset over strobe result", int'(result), 0);
        check("R1 reset over strobe valid", int'(result_valid), 0);
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule